// File: doc/BRIEF.md
# Peripheral Access Protection Filter

This block sits in front of a group of peripheral slaves and decides, for every bus request, whether that request may reach its slave. The address space it guards is cut into 1 KB frames. Each frame holds four 256-byte quadrants. A request is checked against three things: a fixed table of which masters have a hardware path to which frame, a programmable per-quadrant enable bit for the requesting master, and a per-quadrant privilege-protect bit that stops user-mode traffic. A request that passes drives the slave select in the same cycle. A request that fails never reaches the slave and gets an error response instead.

A peripheral may cover more than one quadrant. Only the lowest quadrant of such a span owns the enable field and the protect bit, and the other quadrants of the span follow those settings. Which quadrants are populated, where each span starts, which frames carry protect bits and the master-to-frame connectivity are all elaboration parameters. Only privileged software may change the settings, through a small indexed register port.

Top module: `periph_guard`

## Requirements
- R1: The frame of a request is req_addr[AW-1:10] and its quadrant is req_addr[9:8]. A request to a quadrant that no peripheral occupies, or to a frame at or beyond N_FRAMES, is blocked.
- R2: A master whose bit in MASTER_CONN (bit frame*N_MASTERS+master) is 0 is blocked on that frame whatever its enable bit holds. Writing a 1 into that enable bit does not open the path.
- R3: A request passes only if the enable bit for its master in its effective quadrant is 1. Clearing that bit blocks that master alone.
- R4: The effective quadrant is the highest span-start quadrant (QUAD_LEAD) at or below the addressed quadrant in the same frame. Its enable field and its protect bit govern every quadrant of the span.
- R5: Configuration index 2f holds frame f's quadrant 0 field in bits [15:0] and quadrant 1 in bits [31:16]. Index 2f+1 holds quadrants 2 and 3 the same way. A field of a quadrant that is not a span start reads 0, and writes to it are ignored.
- R6: When the effective quadrant's protect bit is 1, a user-mode request (req_priv=0) is blocked and a privileged request is judged by R2 and R3 only.
- R7: A frame whose USER_FRAMES bit is 0 has no protect bits: those bits read 0, writes to them are ignored, and user-mode requests to it are never blocked for privilege.
- R8: After reset every implemented enable bit is 1 and every protect bit is 0.
- R9: Index 2*N_FRAMES sets protect bits where the write data has a 1. Index 2*N_FRAMES+1 clears them the same way. Both indices read the protect vector, with bit frame*4+quadrant. A 0 in the write data leaves that bit as it was.
- R10: A blocked request raises no slave select. One cycle later it gets rsp_valid=1, rsp_err=1 and rsp_rdata=0. A passing request raises slv_sel in the same cycle. One cycle later it gets rsp_valid=1 and rsp_err=0, with rsp_rdata equal to slv_rdata for a read and 0 for a write.
- R11: Every config access gets cfg_ack one cycle later. A user-mode write, or any access to an index at or beyond 2*N_FRAMES+2, returns cfg_err=1 and cfg_rdata=0 and changes nothing. A read returns the register value and user-mode reads are allowed.
- R12: A config write and a request in the same cycle: the request is judged by the settings that held before the write, and the next request is judged by the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Request byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | 1 for a privileged access |
| req_master | input | MW | Requesting master ID |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_err | output | 1 | Response is a bus error |
| rsp_rdata | output | 32 | Response read data |
| slv_sel | output | 1 | Select strobe to the slave group |
| slv_addr | output | AW | Address toward the slaves |
| slv_write | output | 1 | Direction toward the slaves |
| slv_wdata | output | 32 | Write data toward the slaves |
| slv_rdata | input | 32 | Read data from the selected slave |
| cfg_en | input | 1 | Config access present |
| cfg_we | input | 1 | Config write when 1 |
| cfg_priv | input | 1 | Config access is privileged |
| cfg_idx | input | IW | Config register index |
| cfg_wdata | input | 32 | Config write data |
| cfg_ack | output | 1 | Config access completed |
| cfg_err | output | 1 | Config access rejected |
| cfg_rdata | output | 32 | Config read data |

## Verification
A settings update and a filtered request can land in the same cycle. The directed case clears a protect bit through the clear index while a user-mode request targets that quadrant. The request must still be refused, and an identical request one cycle later must pass. The random phase issues a config write and a request together in about one step in ten. The bench judges every such request against its own settings model as it stood before the write, and applies the write to the model only after the checks.

// File: rtl/pg_pkg.sv
package pg_pkg;
   localparam int QUADS     = 4;
   localparam int QUAD_LSB  = 8;
   localparam int FRAME_LSB = 10;
   localparam int WORD_W    = 32;
   localparam int FIELD_W   = 16;

   typedef enum logic [1:0] {
      RK_MID  = 2'd0,
      RK_PSET = 2'd1,
      RK_PCLR = 2'd2,
      RK_NONE = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/pg_decode.sv
module pg_decode #(
   parameter int NF = 4,
   parameter int NM = 16,
   parameter logic [NF*4-1:0]  MAPPED = '1,
   parameter logic [NF*4-1:0]  LEAD   = '1,
   parameter logic [NF*NM-1:0] CONN   = '1,
   localparam int FW = (NF > 1) ? $clog2(NF) : 1,
   localparam int MW = (NM > 1) ? $clog2(NM) : 1,
   localparam int QW = $clog2(NF*4)
) (
   input  logic [FW-1:0] frame,
   input  logic [1:0]    quad,
   input  logic [MW-1:0] master,
   output logic          hit,
   output logic          conn_ok,
   output logic [QW-1:0] eff_idx
);
   import pg_pkg::*;

   always_comb begin
      int  base;
      int  eq;
      logic found;
      base    = 0;
      eq      = 0;
      found   = 1'b0;
      hit     = 1'b0;
      conn_ok = 1'b0;
      if (int'(frame) < NF && int'(master) < NM) begin
         base = int'(frame) * QUADS;
         for (int k = 0; k < QUADS; k++) begin
            if (k <= int'(quad) && LEAD[base + k]) begin
               eq    = k;
               found = 1'b1;
            end
         end
         hit     = found && MAPPED[base + int'(quad)];
         conn_ok = CONN[int'(frame) * NM + int'(master)];
      end
      eff_idx = QW'(base + eq);
   end
endmodule

// File: rtl/pg_regs.sv
module pg_regs #(
   parameter int NF = 4,
   parameter int NM = 16,
   parameter logic [NF*4-1:0] LEAD  = '1,
   parameter logic [NF-1:0]   USER  = '1,
   localparam int NQ = NF*4,
   localparam int IW = $clog2(2*NF + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_we,
   input  logic             cfg_priv,
   input  logic [IW-1:0]    cfg_idx,
   input  logic [31:0]      cfg_wdata,
   output logic             cfg_ack,
   output logic             cfg_err,
   output logic [31:0]      cfg_rdata,
   output logic [NQ*NM-1:0] en_flat,
   output logic [NQ-1:0]    prot_flat
);
   import pg_pkg::*;

   reg_kind_e   kind;
   logic [31:0] rd_val;
   logic        wr_ok;
   logic        mid_wr;
   logic        pset_wr;
   logic        pclr_wr;

   always_comb begin
      if (int'(cfg_idx) < 2*NF)        kind = RK_MID;
      else if (int'(cfg_idx) == 2*NF)  kind = RK_PSET;
      else if (int'(cfg_idx) == 2*NF+1) kind = RK_PCLR;
      else                             kind = RK_NONE;
   end

   assign wr_ok   = cfg_en && cfg_we && cfg_priv && (kind != RK_NONE);
   assign mid_wr  = wr_ok && (kind == RK_MID);
   assign pset_wr = wr_ok && (kind == RK_PSET);
   assign pclr_wr = wr_ok && (kind == RK_PCLR);

   always_comb begin
      int b;
      b      = 0;
      rd_val = '0;
      if (kind == RK_MID) begin
         b      = (int'(cfg_idx) / 2) * QUADS + (int'(cfg_idx) % 2) * 2;
         rd_val = {FIELD_W'(en_flat[(b+1)*NM +: NM]), FIELD_W'(en_flat[b*NM +: NM])};
      end else if (kind != RK_NONE) begin
         rd_val = WORD_W'(prot_flat);
      end
   end

   for (genvar q = 0; q < NQ; q++) begin : g_q
      localparam int F = q / QUADS;
      localparam int H = (q % QUADS) / 2;
      localparam int L = q % 2;
      if (LEAD[q]) begin : g_en
         logic [NM-1:0] en_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               en_r <= '1;
            else if (mid_wr && int'(cfg_idx) == 2*F + H)
               en_r <= cfg_wdata[L*FIELD_W +: NM];
         end
         assign en_flat[q*NM +: NM] = en_r;
      end else begin : g_no_en
         assign en_flat[q*NM +: NM] = '0;
      end
      if (LEAD[q] && USER[F]) begin : g_prot
         logic p_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               p_r <= 1'b0;
            else if (pset_wr && cfg_wdata[q])
               p_r <= 1'b1;
            else if (pclr_wr && cfg_wdata[q])
               p_r <= 1'b0;
         end
         assign prot_flat[q] = p_r;
      end else begin : g_no_prot
         assign prot_flat[q] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_ack   <= 1'b0;
         cfg_err   <= 1'b0;
         cfg_rdata <= '0;
      end else begin
         cfg_ack   <= cfg_en;
         cfg_err   <= cfg_en && ((kind == RK_NONE) || (cfg_we && !cfg_priv));
         cfg_rdata <= (cfg_en && !cfg_we && kind != RK_NONE) ? rd_val : '0;
      end
   end

   wire unused_wdata = ^cfg_wdata;
endmodule

// File: rtl/pg_gate.sv
module pg_gate #(
   parameter int NF = 4,
   parameter int NM = 16,
   localparam int NQ = NF*4,
   localparam int QW = $clog2(NF*4),
   localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_priv,
   input  logic             req_write,
   input  logic [MW-1:0]    master,
   input  logic             hit,
   input  logic             conn_ok,
   input  logic [QW-1:0]    eff_idx,
   input  logic [NQ*NM-1:0] en_flat,
   input  logic [NQ-1:0]    prot_flat,
   input  logic [31:0]      slv_rdata,
   output logic             slv_sel,
   output logic             rsp_valid,
   output logic             rsp_err,
   output logic [31:0]      rsp_rdata
);
   logic pass;

   always_comb begin
      pass = 1'b0;
      if (req_valid && hit && conn_ok)
         pass = en_flat[int'(eff_idx)*NM + int'(master)] &&
                (req_priv || !prot_flat[eff_idx]);
   end

   assign slv_sel = pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !pass;
         rsp_rdata <= (pass && !req_write) ? slv_rdata : '0;
      end
   end
endmodule

// File: rtl/periph_guard.sv
module periph_guard #(
   parameter int N_FRAMES  = 4,
   parameter int N_MASTERS = 16,
   parameter logic [N_FRAMES*4-1:0]         QUAD_MAPPED = 16'hFFF3,
   parameter logic [N_FRAMES*4-1:0]         QUAD_LEAD   = 16'h1F51,
   parameter logic [N_FRAMES-1:0]           USER_FRAMES = 4'b0111,
   parameter logic [N_FRAMES*N_MASTERS-1:0] MASTER_CONN = 64'h0FFF_00FF_FFFF_FFF7,
   localparam int FW = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1,
   localparam int AW = pg_pkg::FRAME_LSB + FW,
   localparam int MW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
   localparam int IW = $clog2(2*N_FRAMES + 2),
   localparam int NQ = N_FRAMES*4,
   localparam int QW = $clog2(N_FRAMES*4)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   input  logic          req_write,
   input  logic [31:0]   req_wdata,
   input  logic          req_priv,
   input  logic [MW-1:0] req_master,
   output logic          rsp_valid,
   output logic          rsp_err,
   output logic [31:0]   rsp_rdata,
   output logic          slv_sel,
   output logic [AW-1:0] slv_addr,
   output logic          slv_write,
   output logic [31:0]   slv_wdata,
   input  logic [31:0]   slv_rdata,
   input  logic          cfg_en,
   input  logic          cfg_we,
   input  logic          cfg_priv,
   input  logic [IW-1:0] cfg_idx,
   input  logic [31:0]   cfg_wdata,
   output logic          cfg_ack,
   output logic          cfg_err,
   output logic [31:0]   cfg_rdata
);
   import pg_pkg::*;

   if (N_FRAMES < 1 || N_FRAMES > 8) begin : g_bad_frames
      $error("periph_guard: N_FRAMES must lie in 1..8");
   end
   if (N_MASTERS < 1 || N_MASTERS > FIELD_W) begin : g_bad_masters
      $error("periph_guard: N_MASTERS must lie in 1..16");
   end
   for (genvar q = 0; q < NQ; q++) begin : g_span_chk
      if (QUAD_LEAD[q] && !QUAD_MAPPED[q]) begin : g_lead_unmapped
         $error("periph_guard: span start on an empty quadrant");
      end
      if (QUAD_MAPPED[q] && (QUAD_LEAD[(q/QUADS)*QUADS +: (q%QUADS)+1] == '0)) begin : g_no_lead
         $error("periph_guard: populated quadrant without a span start below it");
      end
   end

   logic [NQ*N_MASTERS-1:0] en_flat;
   logic [NQ-1:0]           prot_flat;
   logic                    hit;
   logic                    conn_ok;
   logic [QW-1:0]           eff_idx;

   pg_decode #(
      .NF(N_FRAMES), .NM(N_MASTERS),
      .MAPPED(QUAD_MAPPED), .LEAD(QUAD_LEAD), .CONN(MASTER_CONN)
   ) i_decode (
      .frame   (req_addr[AW-1:FRAME_LSB]),
      .quad    (req_addr[QUAD_LSB+1:QUAD_LSB]),
      .master  (req_master),
      .hit     (hit),
      .conn_ok (conn_ok),
      .eff_idx (eff_idx)
   );

   pg_regs #(
      .NF(N_FRAMES), .NM(N_MASTERS), .LEAD(QUAD_LEAD), .USER(USER_FRAMES)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_en    (cfg_en),
      .cfg_we    (cfg_we),
      .cfg_priv  (cfg_priv),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .cfg_ack   (cfg_ack),
      .cfg_err   (cfg_err),
      .cfg_rdata (cfg_rdata),
      .en_flat   (en_flat),
      .prot_flat (prot_flat)
   );

   pg_gate #(
      .NF(N_FRAMES), .NM(N_MASTERS)
   ) i_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_priv  (req_priv),
      .req_write (req_write),
      .master    (req_master),
      .hit       (hit),
      .conn_ok   (conn_ok),
      .eff_idx   (eff_idx),
      .en_flat   (en_flat),
      .prot_flat (prot_flat),
      .slv_rdata (slv_rdata),
      .slv_sel   (slv_sel),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata)
   );

   assign slv_addr  = req_addr;
   assign slv_write = req_write;
   assign slv_wdata = req_wdata;
endmodule

// File: rtl/periph_guard_chk.sv
module periph_guard_chk #(
   parameter int NF = 4,
   parameter int NM = 16,
   parameter logic [NF*4-1:0]  MAPPED = '1,
   parameter logic [NF*NM-1:0] CONN   = '1,
   localparam int FW = (NF > 1) ? $clog2(NF) : 1,
   localparam int AW = pg_pkg::FRAME_LSB + FW,
   localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic [MW-1:0] req_master,
   input logic          slv_sel,
   input logic          rsp_valid,
   input logic          rsp_err,
   input logic [31:0]   rsp_rdata,
   input logic          cfg_en,
   input logic          cfg_we,
   input logic          cfg_priv,
   input logic          cfg_ack,
   input logic          cfg_err,
   input logic [31:0]   cfg_rdata
);
   logic no_path;
   logic empty_quad;

   always_comb begin
      int fr;
      int qi;
      fr         = int'(req_addr[AW-1:pg_pkg::FRAME_LSB]);
      qi         = int'(req_addr[pg_pkg::QUAD_LSB+1:pg_pkg::QUAD_LSB]);
      no_path    = 1'b0;
      empty_quad = 1'b1;
      if (fr < NF) begin
         empty_quad = !MAPPED[fr*4 + qi];
         if (int'(req_master) < NM)
            no_path = !CONN[fr*NM + int'(req_master)];
      end
   end

   // R10
   pass_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slv_sel |=> rsp_valid && !rsp_err);

   // R10
   block_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !slv_sel |=> rsp_valid && rsp_err && rsp_rdata == 32'h0);

   // R10
   idle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R2
   conn_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && no_path |-> !slv_sel);

   // R1
   empty_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && empty_quad |-> !slv_sel);

   // R11
   user_cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en && cfg_we && !cfg_priv |=> cfg_ack && cfg_err && cfg_rdata == 32'h0);

   // R11
   cfg_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> cfg_ack);
endmodule

bind periph_guard periph_guard_chk #(
   .NF(N_FRAMES), .NM(N_MASTERS), .MAPPED(QUAD_MAPPED), .CONN(MASTER_CONN)
) i_chk (.*);

// File: tb/test_periph_guard.sv
`timescale 1ns/1ps
module test_periph_guard;
   localparam logic [15:0] MAPPED = 16'hFFF3;
   localparam logic [15:0] LEAD   = 16'h1F51;
   localparam logic [3:0]  USER   = 4'b0111;
   localparam logic [63:0] CONN   = 64'h0FFF_00FF_FFFF_FFF7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [11:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        req_priv = 1'b0;
   logic [3:0]  req_master = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        slv_sel, slv_write;
   logic [11:0] slv_addr;
   logic [31:0] slv_wdata, slv_rdata;
   logic        cfg_en = 1'b0, cfg_we = 1'b0, cfg_priv = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_ack, cfg_err;
   logic [31:0] cfg_rdata;

   int checks = 0;
   int fails  = 0;

   logic [15:0] m_en [16];
   logic [15:0] m_prot;

   always #10 clk = ~clk;

   assign slv_rdata = {20'hA5C30, slv_addr};

   periph_guard i_periph_guard (.*);

   function automatic bit model_pass(int m, bit pr, logic [11:0] a);
      int f, q, e;
      f = int'(a[11:10]);
      q = int'(a[9:8]);
      e = 0;
      if (!MAPPED[f*4+q]) return 1'b0;
      for (int k = 0; k <= q; k++) if (LEAD[f*4+k]) e = k;
      return CONN[f*16+m] && m_en[f*4+e][m] && (pr || !m_prot[f*4+e]);
   endfunction

   function automatic logic [31:0] model_reg(int ci);
      int b;
      if (ci < 8) begin
         b = (ci/2)*4 + (ci%2)*2;
         return {m_en[b+1], m_en[b]};
      end
      return {16'h0, m_prot};
   endfunction

   task automatic model_write(int ci, logic [31:0] wd);
      int b;
      logic [15:0] impl;
      for (int i = 0; i < 16; i++) impl[i] = USER[i/4] && LEAD[i];
      if (ci < 8) begin
         b = (ci/2)*4 + (ci%2)*2;
         if (LEAD[b])   m_en[b]   = wd[15:0];
         if (LEAD[b+1]) m_en[b+1] = wd[31:16];
      end else if (ci == 8) begin
         m_prot = m_prot | (wd[15:0] & impl);
      end else begin
         m_prot = m_prot & ~wd[15:0];
      end
   endtask

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(bit da, int m, bit pr, logic [11:0] a, bit wr,
                       bit dc, bit cwe, bit cpr, int ci, logic [31:0] cwd, string tag);
      bit          ep;
      bit          ecerr;
      logic [31:0] erd, ecrd;
      ep    = da && model_pass(m, pr, a);
      erd   = (ep && !wr) ? {20'hA5C30, a} : 32'h0;
      ecerr = (ci >= 10) || (cwe && !cpr);
      ecrd  = (!ecerr && !cwe) ? model_reg(ci) : 32'h0;
      @(negedge clk);
      req_valid = da; req_master = m[3:0]; req_priv = pr; req_addr = a;
      req_write = wr; req_wdata = $urandom;
      cfg_en = dc; cfg_we = cwe; cfg_priv = cpr; cfg_idx = ci[3:0]; cfg_wdata = cwd;
      #1;
      if (da) chk(slv_sel === ep, {tag, " select"}, {31'h0, slv_sel}, {31'h0, ep});
      @(negedge clk);
      req_valid = 1'b0; cfg_en = 1'b0;
      if (da) begin
         chk(rsp_valid === 1'b1 && rsp_err === !ep, {tag, " response"},
             {30'h0, rsp_valid, rsp_err}, {30'h0, 1'b1, !ep});
         chk(rsp_rdata === erd, {tag, " rdata"}, rsp_rdata, erd);
      end
      if (dc) begin
         chk(cfg_ack === 1'b1 && cfg_err === ecerr, {tag, " cfg status"},
             {30'h0, cfg_ack, cfg_err}, {30'h0, 1'b1, ecerr});
         chk(cfg_rdata === ecrd, {tag, " cfg rdata"}, cfg_rdata, ecrd);
         if (!ecerr && cwe) model_write(ci, cwd);
      end
   endtask

   task automatic acc(int m, bit pr, logic [11:0] a, bit wr, string tag);
      step(1'b1, m, pr, a, wr, 1'b0, 1'b0, 1'b0, 0, 32'h0, tag);
   endtask

   task automatic cfg(bit we, bit pr, int ci, logic [31:0] wd, string tag);
      step(1'b0, 0, 1'b0, 12'h0, 1'b0, 1'b1, we, pr, ci, wd, tag);
   endtask

   task automatic rd_lit(int ci, logic [31:0] lit, string tag);
      cfg(1'b0, 1'b1, ci, 32'h0, tag);
      chk(cfg_rdata === lit, {tag, " literal"}, cfg_rdata, lit);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) m_en[i] = LEAD[i] ? 16'hFFFF : 16'h0;
      m_prot = 16'h0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid === 1'b0 && cfg_ack === 1'b0, "R8 reset outputs",
          {30'h0, rsp_valid, cfg_ack}, 32'h0);

      // R8 / R5: reset contents
      for (int ci = 0; ci < 10; ci++) cfg(1'b0, 1'b1, ci, 32'h0, "R8 reset read");
      rd_lit(0, 32'h0000FFFF, "R5 frame0 low");
      rd_lit(1, 32'h0000_0000, "R5 frame0 high unmapped");
      rd_lit(4, 32'hFFFFFFFF, "R8 frame2 low");
      rd_lit(8, 32'h0, "R8 protect clear");

      // R1: empty quadrant
      acc(0, 1'b1, 12'h200, 1'b0, "R1 empty quadrant");
      // R2: no hardware path
      acc(3, 1'b1, 12'h000, 1'b0, "R2 no path frame0");
      cfg(1'b1, 1'b1, 0, 32'hFFFFFFFF, "R2 try to enable");
      rd_lit(0, 32'h0000FFFF, "R5 upper span field ignored");
      acc(3, 1'b1, 12'h010, 1'b0, "R2 still no path");
      acc(9, 1'b1, 12'h800, 1'b0, "R2 no path frame2");
      acc(0, 1'b1, 12'h100, 1'b0, "R4 span quadrant1 follows quadrant0");

      // R3
      cfg(1'b1, 1'b1, 2, 32'h0000FFFE, "R3 clear master0 frame1 q0");
      acc(0, 1'b1, 12'h400, 1'b0, "R3 master0 blocked");
      acc(1, 1'b1, 12'h400, 1'b0, "R3 master1 passes");

      // R4
      cfg(1'b1, 1'b1, 3, 32'hFFFFFFFD, "R4 clear master1 frame1 q2");
      rd_lit(3, 32'h0000FFFD, "R5 q3 field reads zero");
      acc(1, 1'b1, 12'h700, 1'b0, "R4 q3 follows q2");
      acc(0, 1'b1, 12'h7F0, 1'b0, "R4 other master q3");

      // R6
      cfg(1'b1, 1'b1, 8, 32'h00000200, "R6 protect frame2 q1");
      acc(0, 1'b0, 12'h900, 1'b0, "R6 user blocked");
      acc(0, 1'b1, 12'h904, 1'b0, "R6 privileged passes");
      acc(0, 1'b0, 12'h800, 1'b0, "R6 neighbour quadrant open");

      // R7
      cfg(1'b1, 1'b1, 8, 32'h0000F000, "R7 set on system frame");
      rd_lit(8, 32'h00000200, "R7 system bits read zero");
      acc(0, 1'b0, 12'hC00, 1'b0, "R7 user reaches system frame");

      // R4 protect via span start
      cfg(1'b1, 1'b1, 8, 32'h00000010, "R4 protect frame1 q0");
      acc(1, 1'b0, 12'h500, 1'b0, "R4 user q1 blocked via q0");
      acc(1, 1'b1, 12'h500, 1'b0, "R4 privileged q1 passes");

      // R9
      rd_lit(9, 32'h00000210, "R9 clear index reads state");
      cfg(1'b1, 1'b1, 9, 32'h00000010, "R9 clear bit4");
      rd_lit(8, 32'h00000200, "R9 after clear");

      // R11
      cfg(1'b1, 1'b0, 8, 32'h0000FFFF, "R11 user write rejected");
      rd_lit(8, 32'h00000200, "R11 no change");
      cfg(1'b0, 1'b0, 8, 32'h0, "R11 user read allowed");
      cfg(1'b0, 1'b1, 10, 32'h0, "R11 bad index");

      // R12
      step(1'b1, 0, 1'b0, 12'h900, 1'b0, 1'b1, 1'b1, 1'b1, 9, 32'h00000200,
           "R12 same-cycle clear uses old state");
      acc(0, 1'b0, 12'h900, 1'b0, "R12 next access sees new state");

      // R10
      acc(0, 1'b1, 12'hC04, 1'b1, "R10 write passes with zero rdata");
      acc(2, 1'b1, 12'hB3C, 1'b0, "R10 read returns slave data");

      // random phase
      for (int it = 0; it < 2500; it++) begin
         int          r, ci;
         bit          da, dc;
         logic [31:0] wd;
         r  = int'($urandom % 10);
         da = (r != 0 && r != 1 && r != 2);
         dc = (r <= 2) || (r == 9);
         ci = int'($urandom % 12);
         if (ci < 8) wd = $urandom | $urandom;
         else        wd = $urandom & $urandom & $urandom;
         step(da, int'($urandom % 16), ($urandom % 3) != 0, 12'($urandom), $urandom % 2 == 1,
              dc, ($urandom % 4) != 0, ($urandom % 8) != 0, ci, wd,
              "R3 R12 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule